// File: doc/BRIEF.md
# Lane-Structure Vector Transfer Micro-Op Sequencer

This block turns one vector load or store that moves a single lane (or, for loads, a value copied into all lanes) of a structure of one to four elements into a short ordered list of micro-operations. A request names the direction, the all-lanes flag, the element count, the register count, the element size code, the lane, the integer base register, the first vector register, the register stride, the alignment hint and the post-index offset register. The block checks the request, latches it and then emits one micro-op descriptor per cycle on a valid/ready output port.

Each descriptor carries an operation kind, a pack/unpack variant, the transfer byte count, vector destination and source indices, the base and offset register fields, the doubled stride, the lane, the all-lanes flag, the alignment hint and the two commit flags. A load becomes a narrow memory read into a scratch register, an optional base-register update and then one or more unpack steps. A store becomes one or more pack steps, a narrow memory write from the scratch register and an optional base update. Requests that break the shape rules are dropped with a one-cycle error pulse.

Top module: `lane_uop_seq`

## Requirements
- R1: After reset `out_valid` and `err` are 0 and `in_ready` is 1.
- R2: A request is illegal when the size code is 3, when a store has the all-lanes flag, or when (elements, registers) is not one of (4,4), (3,3), (2,2), (1,1), or (1,2) with the all-lanes flag; an accepted illegal request raises `err` for exactly the cycle after acceptance and produces no descriptor.
- R3: A legal request yields 1 + W + M descriptors, where W is 1 when the offset register field is not 15 and M is the register count for one-element structures and 1 otherwise; the final one has `out_last`=1, `out_delay`=0, all earlier ones `out_last`=0, `out_delay`=1, and `out_valid` falls after the final handshake unless a new request is accepted.
- R4: A load emits memory read, then base update, then unpacks; a store emits packs, then memory write, then base update.
- R5: `out_bytes` equals (1 << size code) times the element count on every descriptor.
- R6: Base update kind: offset field 13 gives kind 2 (add `out_bytes` as immediate to the base), any other value except 15 gives kind 3 (add register `out_ofs` to the base), 15 gives no base update.
- R7: Kind codes: 0 memory read, 1 memory write, 2 add immediate, 3 add register, 4 unpack, 5 pack. Variant codes on unpack/pack: 1 two-to-two (one element), 2 two-to-four (two elements), 3 two-to-six (three elements, size 0 or 1), 4 four-to-six (three elements, size 2), 5 two-to-eight (four elements, size 0 or 1), 6 four-to-eight (four elements, size 2); all other kinds carry variant 0.
- R8: For one-element structures there is one unpack or pack per register, register offset o counting from 0, with vector index (first + o) × 2; for larger structures the single unpack or pack uses first × 2.
- R9: While `out_valid` is 1 and `out_ready` is 0 the descriptor is held unchanged; each handshake advances by exactly one descriptor.
- R10: `in_ready` is 1 during the handshake of a final descriptor, so a following request is accepted in that same cycle and its first descriptor (or its error pulse) appears in the next cycle.
- R11: Memory read has destination 64 (the scratch register) and source 0; memory write has destination 0 and source 64; unpack has source 64 and pack has destination 64; base update has both 0; every descriptor carries the request's base, offset field, lane, all-lanes flag, alignment and the stride doubled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_store | input | 1 | 1 store, 0 load |
| in_all | input | 1 | Copy to all lanes (loads only) |
| in_elems | input | 3 | Elements per structure, 1 to 4 |
| in_regs | input | 3 | Vector register count, 1 to 4 |
| in_size | input | 2 | Element size code (bytes = 1 << code) |
| in_lane | input | 3 | Lane index |
| in_base | input | 4 | Integer base register |
| in_first | input | 5 | First vector register |
| in_stride | input | 2 | Register stride |
| in_align | input | 2 | Alignment hint |
| in_ofs | input | 4 | Offset register (15 none, 13 immediate) |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Descriptor taken |
| out_kind | output | 3 | Operation kind |
| out_variant | output | 3 | Pack/unpack variant |
| out_bytes | output | 5 | Transfer byte count |
| out_dst | output | 7 | Vector destination index |
| out_src | output | 7 | Vector source index |
| out_base | output | 4 | Base register |
| out_ofs | output | 4 | Offset register field |
| out_stride | output | 3 | Doubled stride |
| out_lane | output | 3 | Lane index |
| out_all | output | 1 | All-lanes flag |
| out_align | output | 2 | Alignment hint |
| out_delay | output | 1 | Commit deferred |
| out_last | output | 1 | Final micro-op of the request |
| err | output | 1 | Illegal request pulse |

## Verification
The two functions that share a cycle are the handshake of a sequence's final descriptor and the acceptance of the next request. The bench holds the next request on the input while the last descriptor of the previous one is being taken and checks that `in_ready` is high in that cycle, that the new request's first descriptor follows with no gap, and, with an illegal request in the same slot, that `err` pulses while `out_valid` falls. Output stalls are also placed mid-sequence to confirm that a held descriptor does not move.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int FW = 7;   // vector register index width
  localparam int IW = 4;   // integer register index width
  localparam int VW = 5;   // first vector register width
  localparam int LW = 3;   // lane width
  localparam int AW = 2;   // alignment width
  localparam int SW = 2;   // stride width
  localparam int CW = 3;   // element / register count width
  localparam int BW = 5;   // byte count width
  localparam int STW = 2;  // step counter width
  localparam logic [FW-1:0] SCRATCH = FW'(64);
  localparam logic [IW-1:0] OFS_NONE = IW'(15);
  localparam logic [IW-1:0] OFS_IMM = IW'(13);

  typedef enum logic [2:0] {
    K_RD = 3'd0, K_WR = 3'd1, K_ADDI = 3'd2, K_ADDR = 3'd3,
    K_UNPK = 3'd4, K_PACK = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    V_NONE = 3'd0, V_2_2 = 3'd1, V_2_4 = 3'd2, V_2_6 = 3'd3,
    V_4_6 = 3'd4, V_2_8 = 3'd5, V_4_8 = 3'd6
  } var_e;

  typedef struct packed {
    logic          store;
    logic          all;
    logic [CW-1:0] elems;
    logic [CW-1:0] regs;
    logic [1:0]    size;
    logic [LW-1:0] lane;
    logic [IW-1:0] base;
    logic [VW-1:0] first;
    logic [SW-1:0] stride;
    logic [AW-1:0] align;
    logic [IW-1:0] ofs;
  } req_t;

  typedef struct packed {
    kind_e         kind;
    var_e          vsel;
    logic [BW-1:0] bytes;
    logic [FW-1:0] dst;
    logic [FW-1:0] src;
    logic [IW-1:0] base;
    logic [IW-1:0] ofs;
    logic [SW:0]   stride;
    logic [LW-1:0] lane;
    logic          all;
    logic [AW-1:0] align;
    logic          delay;
    logic          last;
  } uop_t;
endpackage

// File: rtl/lus_decode.sv
module lus_decode
  import lus_pkg::*;
(
  input  req_t          r,
  output logic          legal,
  output logic          wb,
  output logic          wb_imm,
  output logic [BW-1:0] bytes,
  output logic [CW-1:0] nmix,
  output logic [CW-1:0] total,
  output var_e          vsel
);
  logic          shape_ok;
  logic          bytes_ok;
  logic [BW-1:0] ebytes;

  assign ebytes = BW'(1) << r.size;
  assign bytes  = BW'(ebytes * BW'(r.elems));
  assign wb     = (r.ofs != OFS_NONE);
  assign wb_imm = (r.ofs == OFS_IMM);
  assign nmix   = (r.elems == CW'(1)) ? r.regs : CW'(1);
  assign total  = CW'(1) + CW'(wb) + nmix;

  always_comb begin
    case (r.elems)
      CW'(4):  shape_ok = (r.regs == CW'(4));
      CW'(3):  shape_ok = (r.regs == CW'(3));
      CW'(2):  shape_ok = (r.regs == CW'(2));
      CW'(1):  shape_ok = (r.regs == CW'(1)) || (r.all && r.regs == CW'(2));
      default: shape_ok = 1'b0;
    endcase
    case (bytes)
      BW'(1), BW'(2), BW'(3), BW'(4),
      BW'(6), BW'(8), BW'(12), BW'(16): bytes_ok = 1'b1;
      default:                          bytes_ok = 1'b0;
    endcase
    case (r.elems)
      CW'(4):  vsel = (r.size == 2'd2) ? V_4_8 : V_2_8;
      CW'(3):  vsel = (r.size == 2'd2) ? V_4_6 : V_2_6;
      CW'(2):  vsel = V_2_4;
      default: vsel = V_2_2;
    endcase
  end

  assign legal = shape_ok && bytes_ok && (r.size != 2'd3) && !(r.store && r.all);
endmodule

// File: rtl/lus_step.sv
module lus_step
  import lus_pkg::*;
(
  input  req_t           r,
  input  logic           wb,
  input  logic           wb_imm,
  input  logic [BW-1:0]  bytes,
  input  logic [CW-1:0]  nmix,
  input  logic [CW-1:0]  total,
  input  var_e           vsel,
  input  logic [STW-1:0] step,
  output uop_t           u
);
  logic [STW-1:0] ofs_idx;
  logic [FW-1:0]  vreg;
  logic [CW-1:0]  stepw;

  assign stepw = CW'(step);
  assign ofs_idx = r.store ? step : (step - STW'(1) - STW'(wb));
  assign vreg = FW'((FW'(r.first) + FW'(ofs_idx)) << 1);

  always_comb begin
    u        = '0;
    u.vsel   = V_NONE;
    u.bytes  = bytes;
    u.base   = r.base;
    u.ofs    = r.ofs;
    u.stride = {r.stride, 1'b0};
    u.lane   = r.lane;
    u.all    = r.all;
    u.align  = r.align;
    u.last   = (stepw + CW'(1) == total);
    u.delay  = !u.last;
    if (r.store) begin
      if (stepw < nmix) begin
        u.kind = K_PACK;
        u.vsel = vsel;
        u.dst  = SCRATCH;
        u.src  = vreg;
      end else if (stepw == nmix) begin
        u.kind = K_WR;
        u.src  = SCRATCH;
      end else begin
        u.kind = wb_imm ? K_ADDI : K_ADDR;
      end
    end else begin
      if (step == '0) begin
        u.kind = K_RD;
        u.dst  = SCRATCH;
      end else if (step == STW'(1) && wb) begin
        u.kind = wb_imm ? K_ADDI : K_ADDR;
      end else begin
        u.kind = K_UNPK;
        u.vsel = vsel;
        u.dst  = vreg;
        u.src  = SCRATCH;
      end
    end
  end
endmodule

// File: rtl/lane_uop_seq.sv
module lane_uop_seq
  import lus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_store,
  input  logic          in_all,
  input  logic [CW-1:0] in_elems,
  input  logic [CW-1:0] in_regs,
  input  logic [1:0]    in_size,
  input  logic [LW-1:0] in_lane,
  input  logic [IW-1:0] in_base,
  input  logic [VW-1:0] in_first,
  input  logic [SW-1:0] in_stride,
  input  logic [AW-1:0] in_align,
  input  logic [IW-1:0] in_ofs,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [2:0]    out_variant,
  output logic [BW-1:0] out_bytes,
  output logic [FW-1:0] out_dst,
  output logic [FW-1:0] out_src,
  output logic [IW-1:0] out_base,
  output logic [IW-1:0] out_ofs,
  output logic [SW:0]   out_stride,
  output logic [LW-1:0] out_lane,
  output logic          out_all,
  output logic [AW-1:0] out_align,
  output logic          out_delay,
  output logic          out_last,
  output logic          err
);
  req_t           in_req, held, sel_req;
  uop_t           o_desc, nxt;
  logic           o_valid, err_q;
  logic [STW-1:0] step, sel_step;
  logic           accept, advance;
  logic           legal, wb, wb_imm;
  logic [BW-1:0]  bytes;
  logic [CW-1:0]  nmix, total;
  var_e           vsel;

  always_comb begin
    in_req.store  = in_store;
    in_req.all    = in_all;
    in_req.elems  = in_elems;
    in_req.regs   = in_regs;
    in_req.size   = in_size;
    in_req.lane   = in_lane;
    in_req.base   = in_base;
    in_req.first  = in_first;
    in_req.stride = in_stride;
    in_req.align  = in_align;
    in_req.ofs    = in_ofs;
  end

  assign in_ready = !o_valid || (out_ready && o_desc.last);
  assign accept   = in_valid && in_ready;
  assign advance  = o_valid && out_ready && !o_desc.last;
  assign sel_req  = accept ? in_req : held;
  assign sel_step = accept ? '0 : step + STW'(1);

  lus_decode u_dec (
    .r(sel_req), .legal(legal), .wb(wb), .wb_imm(wb_imm), .bytes(bytes),
    .nmix(nmix), .total(total), .vsel(vsel)
  );

  lus_step u_step (
    .r(sel_req), .wb(wb), .wb_imm(wb_imm), .bytes(bytes), .nmix(nmix),
    .total(total), .vsel(vsel), .step(sel_step), .u(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      err_q   <= 1'b0;
      step    <= '0;
      held    <= '0;
      o_desc  <= '0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) begin
        held    <= in_req;
        step    <= '0;
        o_valid <= 1'b1;
        o_desc  <= nxt;
      end else if (advance) begin
        step   <= sel_step;
        o_desc <= nxt;
      end else if (o_valid && out_ready) begin
        o_valid <= 1'b0;
      end
    end
  end

  assign out_valid   = o_valid;
  assign err         = err_q;
  assign out_kind    = o_desc.kind;
  assign out_variant = o_desc.vsel;
  assign out_bytes   = o_desc.bytes;
  assign out_dst     = o_desc.dst;
  assign out_src     = o_desc.src;
  assign out_base    = o_desc.base;
  assign out_ofs     = o_desc.ofs;
  assign out_stride  = o_desc.stride;
  assign out_lane    = o_desc.lane;
  assign out_all     = o_desc.all;
  assign out_align   = o_desc.align;
  assign out_delay   = o_desc.delay;
  assign out_last    = o_desc.last;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    o_valid && !out_ready |=> o_valid && $stable(o_desc));
  p_continue_r3: assert property (@(posedge clk) disable iff (rst)
    o_valid && out_ready && !o_desc.last |=> o_valid);
  p_drain_r3: assert property (@(posedge clk) disable iff (rst)
    o_valid && out_ready && o_desc.last && !in_valid |=> !o_valid);
  p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    err |-> !o_valid);
  p_mix_var_r7: assert property (@(posedge clk) disable iff (rst)
    o_valid && (o_desc.kind == K_UNPK || o_desc.kind == K_PACK) |-> o_desc.vsel != V_NONE);
  p_b2b_r10: assert property (@(posedge clk) disable iff (rst)
    o_valid && out_ready && o_desc.last && in_valid |=> (o_valid || err));
endmodule

// File: tb/lane_uop_seq_bench.sv
module lane_uop_seq_bench;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_store, in_all;
  logic [2:0] in_elems, in_regs, in_lane;
  logic [1:0] in_size, in_stride, in_align;
  logic [3:0] in_base, in_ofs;
  logic [4:0] in_first;
  logic out_valid, out_ready;
  logic [2:0] out_kind, out_variant, out_stride, out_lane;
  logic [4:0] out_bytes;
  logic [6:0] out_dst, out_src;
  logic [3:0] out_base, out_ofs;
  logic out_all, out_delay, out_last, err;
  logic [1:0] out_align;

  int checks = 0;
  int fails = 0;
  logic [43:0] exp_op [4];
  int exp_n;

  always #2 clk = ~clk;

  lane_uop_seq u_lane_uop_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_all(in_all), .in_elems(in_elems), .in_regs(in_regs),
    .in_size(in_size), .in_lane(in_lane), .in_base(in_base), .in_first(in_first),
    .in_stride(in_stride), .in_align(in_align), .in_ofs(in_ofs),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_variant(out_variant), .out_bytes(out_bytes), .out_dst(out_dst),
    .out_src(out_src), .out_base(out_base), .out_ofs(out_ofs),
    .out_stride(out_stride), .out_lane(out_lane), .out_all(out_all),
    .out_align(out_align), .out_delay(out_delay), .out_last(out_last), .err(err)
  );

  function automatic logic [43:0] actual();
    return {out_kind, out_variant, out_bytes, out_dst, out_src, out_base, out_ofs,
            out_stride, out_lane, out_all, out_align, out_delay, out_last};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic set_req(input bit st, input bit al, input int el, input int rg,
                         input int sz, input int ln, input int bs, input int fr,
                         input int sd, input int ag, input int of);
    in_store = st; in_all = al; in_elems = 3'(el); in_regs = 3'(rg);
    in_size = 2'(sz); in_lane = 3'(ln); in_base = 4'(bs); in_first = 5'(fr);
    in_stride = 2'(sd); in_align = 2'(ag); in_ofs = 4'(of);
  endtask

  // Expected list from R3..R8, R11 using the request now on the inputs.
  task automatic build_exp();
    int nbytes, nmix, k;
    logic [2:0] var_code;
    logic [6:0] vr;
    logic [16:0] tail;
    logic [43:0] wbop;
    nbytes = (1 << in_size) * in_elems;
    nmix = (in_elems == 1) ? int'(in_regs) : 1;
    case (in_elems)
      3'd4: var_code = (in_size == 2) ? 3'd6 : 3'd5;
      3'd3: var_code = (in_size == 2) ? 3'd4 : 3'd3;
      3'd2: var_code = 3'd2;
      default: var_code = 3'd1;
    endcase
    tail = {in_base, in_ofs, in_stride, 1'b0, in_lane, in_all, in_align};
    wbop = {(in_ofs == 4'd13) ? 3'd2 : 3'd3, 3'd0, 5'(nbytes), 7'd0, 7'd0, tail, 2'b10};
    k = 0;
    if (!in_store) begin
      exp_op[k] = {3'd0, 3'd0, 5'(nbytes), 7'd64, 7'd0, tail, 2'b10}; k++;
      if (in_ofs != 4'd15) begin exp_op[k] = wbop; k++; end
      for (int o = 0; o < nmix; o++) begin
        vr = 7'((int'(in_first) + o) * 2);
        exp_op[k] = {3'd4, var_code, 5'(nbytes), vr, 7'd64, tail, 2'b10}; k++;
      end
    end else begin
      for (int o = 0; o < nmix; o++) begin
        vr = 7'((int'(in_first) + o) * 2);
        exp_op[k] = {3'd5, var_code, 5'(nbytes), 7'd64, vr, tail, 2'b10}; k++;
      end
      exp_op[k] = {3'd1, 3'd0, 5'(nbytes), 7'd0, 7'd64, tail, 2'b10}; k++;
      if (in_ofs != 4'd15) begin exp_op[k] = wbop; k++; end
    end
    exp_op[k-1][1:0] = 2'b01;
    exp_n = k;
  endtask

  task automatic issue();
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 idle in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  // Called with descriptor 0 visible; stall = index to hold for 3 cycles.
  task automatic drain(input int stall, input string tag);
    for (int i = 0; i < exp_n; i++) begin
      chk(out_valid && actual() == exp_op[i], tag, 64'({out_valid, actual()}),
          64'({1'b1, exp_op[i]}));
      if (i == stall) begin
        out_ready = 1'b0;
        repeat (3) begin
          @(negedge clk); #1;
          chk(out_valid && actual() == exp_op[i], "R9 held while stalled",
              64'({out_valid, actual()}), 64'({1'b1, exp_op[i]}));
        end
        out_ready = 1'b1;
      end
      @(negedge clk); #1;
    end
    chk(!out_valid && !err, "R3 sequence ends", 64'({out_valid, err}), 64'd0);
  endtask

  task automatic run_legal(input bit st, input bit al, input int el, input int rg,
                           input int sz, input int ln, input int bs, input int fr,
                           input int sd, input int ag, input int of, input int stall,
                           input string tag);
    set_req(st, al, el, rg, sz, ln, bs, fr, sd, ag, of);
    build_exp();
    issue();
    drain(stall, tag);
  endtask

  task automatic run_illegal(input bit st, input bit al, input int el, input int rg,
                             input int sz, input string tag);
    set_req(st, al, el, rg, sz, 1, 2, 3, 1, 0, 15);
    issue();
    chk(err && !out_valid, tag, 64'({err, out_valid}), 64'b10);
    @(negedge clk); #1;
    chk(!err && !out_valid, "R2 error lasts one cycle", 64'({err, out_valid}), 64'b00);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    set_req(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 15);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && !err && in_ready, "R1 reset state",
        64'({out_valid, err, in_ready}), 64'b001);
  endtask

  task automatic t_loads();
    run_legal(0, 0, 4, 4, 0, 5, 3, 2, 1, 1, 5, -1, "R4 R6 R7 load 4 elem reg writeback");
    run_legal(0, 1, 3, 3, 2, 0, 9, 7, 0, 2, 13, -1, "R5 R6 R7 load 3 elem imm writeback");
    run_legal(0, 0, 2, 2, 1, 3, 1, 4, 2, 0, 15, -1, "R3 R7 load 2 elem no writeback");
    run_legal(0, 1, 1, 2, 2, 0, 6, 30, 1, 3, 13, 1, "R8 R9 load 1 elem two regs");
    run_legal(0, 0, 4, 4, 2, 1, 2, 0, 3, 0, 15, -1, "R5 R7 load 4 elem size 2");
    run_legal(0, 0, 1, 1, 0, 7, 4, 11, 0, 1, 15, -1, "R7 R11 load 1 elem");
  endtask

  task automatic t_stores();
    run_legal(1, 0, 4, 4, 1, 2, 8, 1, 1, 0, 13, 0, "R4 R9 store 4 elem imm writeback");
    run_legal(1, 0, 2, 2, 2, 1, 5, 10, 0, 2, 7, -1, "R4 R6 store 2 elem reg writeback");
    run_legal(1, 0, 1, 1, 1, 6, 0, 9, 2, 1, 15, -1, "R8 R11 store 1 elem");
    run_legal(1, 0, 3, 3, 0, 4, 12, 20, 1, 0, 15, -1, "R5 R7 store 3 elem size 0");
  endtask

  task automatic t_illegal();
    run_illegal(0, 0, 4, 4, 3, "R2 size code 3");
    run_illegal(1, 1, 2, 2, 0, "R2 store with all lanes");
    run_illegal(0, 0, 1, 2, 0, "R2 one elem two regs without all");
    run_illegal(0, 0, 2, 4, 1, "R2 two elem four regs");
    run_illegal(0, 0, 0, 0, 0, "R2 zero elements");
  endtask

  task automatic t_back_to_back();
    // Legal request follows a final handshake in the same cycle.
    set_req(0, 0, 2, 2, 0, 2, 3, 5, 1, 0, 15);
    build_exp();
    issue();
    chk(out_valid && actual() == exp_op[0], "R10 first of A", 64'(actual()), 64'(exp_op[0]));
    @(negedge clk); #1;
    chk(out_valid && out_last && actual() == exp_op[1], "R10 last of A",
        64'(actual()), 64'(exp_op[1]));
    set_req(1, 0, 4, 4, 2, 3, 7, 6, 2, 1, 13);
    build_exp();
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 ready on final handshake", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    drain(-1, "R10 second request with no gap");
    // Illegal request in the same slot.
    set_req(0, 0, 3, 3, 1, 0, 1, 2, 0, 0, 15);
    build_exp();
    issue();
    chk(out_valid && actual() == exp_op[0], "R10 first of C", 64'(actual()), 64'(exp_op[0]));
    @(negedge clk); #1;
    set_req(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 15);
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 ready for illegal on final", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(err && !out_valid, "R2 R10 error with final handshake", 64'({err, out_valid}), 64'b10);
    @(negedge clk); #1;
    chk(!err && !out_valid, "R2 pulse ends", 64'({err, out_valid}), 64'b00);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_stores();
    t_illegal();
    t_back_to_back();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end
endmodule